// File: doc/BRIEF.md
# ADC Result Formatter and Data Register Block

This block is the digital back end of a 10-bit successive-approximation converter. A converter core, which is outside the block, hands it a 10-bit result together with a one-cycle done strobe. The block arranges the result into two 8-bit data bytes, high and low, using one of four layouts. It also keeps a conversion-complete flag and the control bits that start a single conversion or a continuous series.

Software reaches the block through a byte-wide register bus with a write strobe and a read strobe. There are four registers: control/status, format, data high and data low. When the high byte is read in any layout except 8-bit truncation, a read lock is set. While the lock is held, new results are thrown away, so the high and low bytes of one result always belong together. Reading the low byte releases the lock.

Top module: `adc_result_fmt`

## Requirements
- R1: After reset, all four registers read 0x00 and the lock is clear. Register addresses are: 0 control/status, 1 format, 2 data high, 3 data low. In control/status, bit 0 is the enable bit, bit 1 selects continuous mode and bit 7 is the read-only complete flag. In the format register, bits 1:0 hold the layout. Unused bits read as zero.
- R2: Layout 01 (right) puts result[9:8] in data-high bits 1:0 and result[7:0] in data low.
- R3: Layout 10 (left) puts result[9:2] in data high and result[1:0] in data-low bits 7:6.
- R4: Layout 11 (left, signed) uses the layout-10 arrangement with result bit 9 inverted.
- R5: Layout 00 (truncation) puts result[9:2] in data low, and data high reads as zero.
- R6: A done strobe stores a result and sets the complete flag only while the enable bit is 1. With the enable bit at 0, the data bytes do not change.
- R7: In single mode (bit 1 = 0), the enable bit clears itself in the cycle after a result is stored, so later strobes are ignored.
- R8: In continuous mode, the enable bit stays set, and every strobe overwrites the data bytes whether or not the previous result was read.
- R9: Reading data high in any layout other than 00 sets the lock. While the lock is held, strobes are discarded. Reading data low clears the lock.
- R10: In layout 00, reading data high does not lock, so a later strobe is stored.
- R11: The complete flag clears on any write to control/status, or on a read of data low in a cycle with no store. If a store and a clear happen in the same cycle, the store wins and the flag is set.
- R12: Read data appears on `rd_data` one clock after the `rd_en` cycle, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| conv_done | input | 1 | One-cycle strobe from the converter core |
| conv_result | input | 10 | Raw conversion result |
| conv_enable | output | 1 | Enable bit, which tells the core to convert |
| conv_complete | output | 1 | Complete flag |

## Verification
On every cycle, the assertions check the following:
- the data bytes hold still while the enable bit is 0 or the lock blocks a store;
- every accepted strobe sets the flag;
- a store in single mode drops the enable bit;
- a low-byte read with no store clears the flag.

Only the bench scenarios can show the following:
- the exact bit placement of the four layouts;
- the order of high and low reads that sets and releases the lock;
- the absence of the lock in truncation layout;
- overwrite of unread results in continuous mode.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    FMT_TRUNC8      = 2'b00,
    FMT_RIGHT       = 2'b01,
    FMT_LEFT        = 2'b10,
    FMT_LEFT_SIGNED = 2'b11
  } fmt_mode_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_FMT  = 2'd1;
  localparam logic [1:0] REG_HI   = 2'd2;
  localparam logic [1:0] REG_LO   = 2'd3;
endpackage

// File: rtl/adc_fmt_unit.sv
module adc_fmt_unit
  import adc_fmt_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8
) (
  input  fmt_mode_e          mode,
  input  logic [RES_W-1:0]   res,
  output logic [DATA_W-1:0]  fmt_hi,
  output logic [DATA_W-1:0]  fmt_lo
);
  localparam int EXTRA_W = RES_W - DATA_W;
  localparam int PAD_W   = DATA_W - EXTRA_W;

  logic [DATA_W-1:0] upper;
  logic [EXTRA_W-1:0] lower;

  assign upper = res[RES_W-1 -: DATA_W];
  assign lower = res[EXTRA_W-1:0];

  always_comb begin
    fmt_hi = '0;
    fmt_lo = '0;
    case (mode)
      FMT_RIGHT: begin
        fmt_hi = {{PAD_W{1'b0}}, res[RES_W-1:DATA_W]};
        fmt_lo = res[DATA_W-1:0];
      end
      FMT_LEFT: begin
        fmt_hi = upper;
        fmt_lo = {lower, {PAD_W{1'b0}}};
      end
      FMT_LEFT_SIGNED: begin
        fmt_hi = {~upper[DATA_W-1], upper[DATA_W-2:0]};
        fmt_lo = {lower, {PAD_W{1'b0}}};
      end
      default: begin
        fmt_hi = '0;
        fmt_lo = upper;
      end
    endcase
  end
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_fmt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic              conv_done,
  output logic              en_q,
  output logic              cont_q,
  output fmt_mode_e         mode_q,
  output logic              flag_q,
  output logic              lock_q,
  output logic              store_en
);
  logic blocked;

  assign blocked  = lock_q && (mode_q != FMT_TRUNC8);
  assign store_en = conv_done && en_q && !blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      cont_q <= 1'b0;
      mode_q <= FMT_TRUNC8;
      flag_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata[0];
        cont_q <= wdata[1];
      end else if (store_en && !cont_q) begin
        en_q <= 1'b0;
      end

      if (wr_fmt)
        mode_q <= fmt_mode_e'(wdata[1:0]);

      if (store_en)
        flag_q <= 1'b1;
      else if (wr_ctrl || rd_lo)
        flag_q <= 1'b0;

      if (rd_lo)
        lock_q <= 1'b0;
      else if (rd_hi && mode_q != FMT_TRUNC8)
        lock_q <= 1'b1;
    end
  end

  // R6
  store_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && en_q && !(lock_q && mode_q != FMT_TRUNC8)) |=> flag_q);

  // R7
  single_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (store_en && !cont_q && !wr_ctrl) |=> !en_q);

  // R11
  lo_read_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !conv_done) |=> !flag_q);
endmodule

// File: rtl/adc_data_regs.sv
module adc_data_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              store_en,
  input  logic [DATA_W-1:0] fmt_hi,
  input  logic [DATA_W-1:0] fmt_lo,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (store_en) begin
      hi_q <= fmt_hi;
      lo_q <= fmt_lo;
    end
  end
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_fmt_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              conv_enable,
  output logic              conv_complete
);
  localparam int FLAG_BIT = DATA_W - 1;

  logic              wr_ctrl, wr_fmt, rd_hi, rd_lo;
  logic              en_q, cont_q, flag_q, lock_q, store_en;
  fmt_mode_e         mode_q;
  logic [DATA_W-1:0] fmt_hi, fmt_lo, hi_q, lo_q, rd_mux;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(REG_CTRL));
  assign wr_fmt  = wr_en && (addr == ADDR_W'(REG_FMT));
  assign rd_hi   = rd_en && (addr == ADDR_W'(REG_HI));
  assign rd_lo   = rd_en && (addr == ADDR_W'(REG_LO));

  adc_fmt_unit #(.RES_W(RES_W), .DATA_W(DATA_W)) fmt_u (
    .mode(mode_q), .res(conv_result), .fmt_hi(fmt_hi), .fmt_lo(fmt_lo)
  );

  adc_ctrl_regs #(.DATA_W(DATA_W)) ctrl_u (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_fmt(wr_fmt), .wdata(wr_data),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .conv_done(conv_done),
    .en_q(en_q), .cont_q(cont_q), .mode_q(mode_q), .flag_q(flag_q),
    .lock_q(lock_q), .store_en(store_en)
  );

  adc_data_regs #(.DATA_W(DATA_W)) data_u (
    .clk(clk), .rst(rst), .store_en(store_en),
    .fmt_hi(fmt_hi), .fmt_lo(fmt_lo), .hi_q(hi_q), .lo_q(lo_q)
  );

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(REG_CTRL): begin
        rd_mux[FLAG_BIT] = flag_q;
        rd_mux[1]        = cont_q;
        rd_mux[0]        = en_q;
      end
      ADDR_W'(REG_FMT): rd_mux[1:0] = mode_q;
      ADDR_W'(REG_HI):  rd_mux = hi_q;
      default:          rd_mux = lo_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_mux;
  end

  assign conv_enable   = en_q;
  assign conv_complete = flag_q;

  // R6
  idle_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> ($stable(hi_q) && $stable(lo_q)));

  // R9
  lock_blocks_store_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q && mode_q != FMT_TRUNC8) |=> ($stable(hi_q) && $stable(lo_q)));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/adc_result_fmt_tb_top.sv
module adc_result_fmt_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, rd_en, conv_done;
  logic [1:0] addr;
  logic [7:0] wr_data, rd_data;
  logic [9:0] conv_result;
  logic       conv_enable, conv_complete;
  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  adc_result_fmt dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .conv_done(conv_done),
    .conv_result(conv_result), .conv_enable(conv_enable),
    .conv_complete(conv_complete)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic conv(logic [9:0] r);
    @(negedge clk);
    conv_done = 1'b1; conv_result = r;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 0; rd_en = 0; conv_done = 0; addr = 0; wr_data = 0;
    conv_result = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reset reg", d, 8'h00);
    end
  endtask

  task automatic t_format(logic [1:0] mode, logic [7:0] exp_hi, logic [7:0] exp_lo,
                          string req);
    logic [7:0] d;
    do_reset();
    wr(2'd1, {6'd0, mode});
    wr(2'd0, 8'h01);
    conv(10'h2A5);
    rd(2'd2, d); check({req, " hi"}, d, exp_hi);
    rd(2'd3, d); check({req, " lo"}, d, exp_lo);
  endtask

  task automatic t_single();
    logic [7:0] d;
    do_reset();
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h01);
    conv(10'h123);
    rd(2'd0, d); check("R7 enable self-cleared, flag set", d, 8'h80);
    conv(10'h0FF);
    rd(2'd3, d); check("R7 second strobe ignored", d, 8'h23);
    rd(2'd0, d); check("R11 lo read clears flag", d, 8'h00);
    conv(10'h3C4);
    rd(2'd3, d); check("R6 disabled strobe ignored", d, 8'h23);
    rd(2'd0, d); check("R6 flag not set while disabled", d, 8'h00);
  endtask

  task automatic t_continuous();
    logic [7:0] d;
    do_reset();
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h03);
    conv(10'h111);
    conv(10'h2EE);
    rd(2'd3, d); check("R8 overwrite unread", d, 8'hEE);
    rd(2'd0, d); check("R8 enable stays set", d, 8'h03);
    conv(10'h155);
    rd(2'd0, d); check("R11 flag set again", d, 8'h83);
    wr(2'd0, 8'h02);
    rd(2'd0, d); check("R11 ctrl write clears flag", d, 8'h02);
    conv(10'h077);
    rd(2'd3, d); check("R6 data held after disable", d, 8'h55);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    do_reset();
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h03);
    conv(10'h2A5);
    rd(2'd2, d); check("R9 hi of first", d, 8'hA9);
    conv(10'h0FF);
    rd(2'd0, d); check("R9 flag cleared only by lo read", d, 8'h83);
    rd(2'd3, d); check("R9 locked strobe discarded", d, 8'h40);
    conv(10'h0FF);
    rd(2'd2, d); check("R9 store after unlock", d, 8'h3F);
    rd(2'd3, d); check("R9 store after unlock lo", d, 8'hC0);
  endtask

  task automatic t_trunc_nolock();
    logic [7:0] d;
    do_reset();
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h03);
    conv(10'h2A5);
    rd(2'd2, d); check("R10 hi zero", d, 8'h00);
    conv(10'h3FC);
    rd(2'd3, d); check("R10 no lock in trunc", d, 8'hFF);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    do_reset();
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h03);
    @(negedge clk);
    rd_en = 1'b1; addr = 2'd3; conv_done = 1'b1; conv_result = 10'h001;
    @(negedge clk);
    rd_en = 1'b0; conv_done = 1'b0;
    rd(2'd0, d); check("R11 store beats lo-read clear", d, 8'h83);
    rd(2'd1, d); check("R12 rd_data fresh per read", d, 8'h01);
    @(negedge clk);
    check("R12 rd_data holds", rd_data, 8'h01);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_format(2'b01, 8'h02, 8'hA5, "R2 right");
    t_format(2'b10, 8'hA9, 8'h40, "R3 left");
    t_format(2'b11, 8'h29, 8'h40, "R4 signed");
    t_format(2'b00, 8'h00, 8'hA9, "R5 trunc");
    t_single();
    t_continuous();
    t_lock();
    t_trunc_nolock();
    t_collide();
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule